// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation structure from memory. A requester presents a virtual address, a write flag and a user flag. Alongside the request, a root register gives the physical location of the first-level directory. The walker fetches one directory word. If that word maps a 4 MB region directly, the walk ends there. Otherwise it fetches one word from the second-level table named by the directory word and forms a 4 KB mapping.

Each word read checks the entry's valid flag first and then its access flags. The result comes back as a one-cycle completion pulse. The pulse carries either the physical address or a fault code. Memory is reached through a single request channel with a valid/ready handshake and a response channel with a valid strobe. Both channels tolerate any number of stall cycles. Only one walk is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `mem_req_valid` is 0 and `done` is 0.
- R2: The first memory read goes to the word address {root[31:12], vaddr[31:22], 2'b00}.
- R3: When the directory word does not end the walk, the second read goes to {dirword[31:12], vaddr[21:12], 2'b00}.
- R4: A successful 4 KB walk reports `done_fault` = 0 and `done_paddr` = {tableword[31:12], vaddr[11:0]}.
- R5: A directory word with bit 7 set, and no fault, ends the walk after one read with `done_paddr` = {dirword[31:22], vaddr[21:0]}.
- R6: A word with bit 0 (valid) clear ends the walk at that level with `done_fault` = 1, and no further read is issued.
- R7: A write request meeting a word with bit 1 (writable) clear, at either level, ends the walk there with `done_fault` = 2.
- R8: A user request meeting a word with bit 2 (user) clear, at either level, ends the walk with `done_fault` = 2. A word that has bit 0 clear reports code 1 whatever its other bits are.
- R9: A memory request stays asserted, with a stable address, until `mem_req_ready` is seen. A response may arrive any number of cycles later.
- R10: `done` is high for exactly one cycle per walk. `req_ready` is 0 from the cycle after acceptance until the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| req_user | input | 1 | Access comes from unprivileged code |
| root_base | input | 32 | Physical address of the first-level directory (bits 31..12 used) |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory takes the read this cycle |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Returned entry word |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Translated address, 0 when faulted |
| done_fault | output | 2 | 0 none, 1 not valid, 2 access denied |

## Verification
The checks assume that memory returns exactly one response for each accepted read, and only while the walker waits for it. They also assume a caller that offers a new request only when `req_ready` is high. The bench plays the memory itself. It raises `mem_rsp_valid` once per accepted read, after a chosen delay, and it deasserts `req_valid` in the cycle after acceptance. The stall and latency settings it uses range from zero to several cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PERM   = 2'd2
  } fault_t;

  localparam int BIT_VALID    = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USER     = 2;
  localparam int BIT_LARGE    = 7;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-OFF_W-1:0] base_pfn,
  input  logic [IDX_W-1:0]        index,
  output logic [ADDR_W-1:0]       word_addr
);
  localparam int PAD_W = ADDR_W - (ADDR_W - OFF_W) - IDX_W;

  // table is one frame of 2**IDX_W words; the low bits select the byte within a word
  assign word_addr = {base_pfn, index, {PAD_W{1'b0}}};
endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
(
  input  logic   valid_bit,
  input  logic   writable_bit,
  input  logic   user_bit,
  input  logic   is_write,
  input  logic   is_user,
  output fault_t verdict
);
  always_comb begin
    if (!valid_bit)
      verdict = FLT_ABSENT;
    else if ((is_write && !writable_bit) || (is_user && !user_bit))
      verdict = FLT_PERM;
    else
      verdict = FLT_NONE;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] root_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic [ADDR_W-1:0] done_paddr,
  output logic [1:0]        done_fault
);
  localparam int PFN_W  = ADDR_W - OFF_W;
  localparam int TBL_LO = OFF_W;
  localparam int DIR_LO = OFF_W + IDX_W;

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_RQ, S_DIR_WT, S_TBL_RQ, S_TBL_WT
  } state_t;

  state_t            state;
  logic [ADDR_W-1:0] va_q;
  logic              wr_q, us_q;
  logic [PFN_W-1:0]  root_q;
  logic [PFN_W-1:0]  dir_pfn_q;

  logic [PFN_W-1:0]  sel_pfn;
  logic [IDX_W-1:0]  sel_idx;
  fault_t            verdict;
  logic              unused_flags;

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_DIR_RQ) || (state == S_TBL_RQ);

  always_comb begin
    if (state == S_TBL_RQ) begin
      sel_pfn = dir_pfn_q;
      sel_idx = va_q[DIR_LO-1:TBL_LO];
    end else begin
      sel_pfn = root_q;
      sel_idx = va_q[ADDR_W-1:DIR_LO];
    end
  end

  ptw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) addr_i (
    .base_pfn (sel_pfn),
    .index    (sel_idx),
    .word_addr(mem_req_addr)
  );

  ptw_entry_check chk_i (
    .valid_bit   (mem_rsp_data[BIT_VALID]),
    .writable_bit(mem_rsp_data[BIT_WRITABLE]),
    .user_bit    (mem_rsp_data[BIT_USER]),
    .is_write    (wr_q),
    .is_user     (us_q),
    .verdict     (verdict)
  );

  assign unused_flags = ^{mem_rsp_data[OFF_W-1:BIT_LARGE+1],
                          mem_rsp_data[BIT_LARGE-1:BIT_USER+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      us_q       <= 1'b0;
      root_q     <= '0;
      dir_pfn_q  <= '0;
      done       <= 1'b0;
      done_paddr <= '0;
      done_fault <= FLT_NONE;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            wr_q   <= req_write;
            us_q   <= req_user;
            root_q <= root_base[ADDR_W-1:OFF_W];
            state  <= S_DIR_RQ;
          end
        end
        S_DIR_RQ: if (mem_req_ready) state <= S_DIR_WT;
        S_DIR_WT: begin
          if (mem_rsp_valid) begin
            if (verdict != FLT_NONE) begin
              done       <= 1'b1;
              done_fault <= verdict;
              done_paddr <= '0;
              state      <= S_IDLE;
            end else if (mem_rsp_data[BIT_LARGE]) begin
              done       <= 1'b1;
              done_fault <= FLT_NONE;
              done_paddr <= {mem_rsp_data[ADDR_W-1:DIR_LO], va_q[DIR_LO-1:0]};
              state      <= S_IDLE;
            end else begin
              dir_pfn_q <= mem_rsp_data[ADDR_W-1:OFF_W];
              state     <= S_TBL_RQ;
            end
          end
        end
        S_TBL_RQ: if (mem_req_ready) state <= S_TBL_WT;
        S_TBL_WT: begin
          if (mem_rsp_valid) begin
            done       <= 1'b1;
            done_fault <= verdict;
            done_paddr <= (verdict == FLT_NONE) ?
                          {mem_rsp_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic [1:0]        done_fault
);
  logic [1:0] reads_q;

  always_ff @(posedge clk) begin
    if (rst) reads_q <= 2'd0;
    else if (req_valid && req_ready) reads_q <= 2'd0;
    else if (mem_req_valid && mem_req_ready && reads_q != 2'd3) reads_q <= reads_q + 2'd1;
  end

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00); // R2
  AST_READS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    done |-> (reads_q == 2'd1 || reads_q == 2'd2)); // R5
  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    done |-> done_fault != 2'd3); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R10
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rsp_valid)); // R4
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) chk_bind_i (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .done         (done),
  .done_fault   (done_fault)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0, root_base = '0;
  logic        req_ready, mem_req_valid, done;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, mem_rsp_data = '0, done_paddr;
  logic [1:0]  done_fault;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [31:0] pmem [logic [31:0]];

  always #2.5 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .root_base(root_base), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .done_paddr(done_paddr), .done_fault(done_fault)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural expectation of one walk
  task automatic model(input logic [31:0] va, input bit w, input bit u, input logic [31:0] base,
                       output logic [31:0] a0, output logic [31:0] a1, output int n,
                       output logic [1:0] f, output logic [31:0] pa);
    logic [31:0] e;
    a0 = {base[31:12], va[31:22], 2'b00};
    a1 = '0; n = 1; pa = '0;
    e = rd(a0);
    if (!e[0]) f = 2'd1;
    else if ((w && !e[1]) || (u && !e[2])) f = 2'd2;
    else if (e[7]) begin f = 2'd0; pa = {e[31:22], va[21:0]}; end
    else begin
      a1 = {e[31:12], va[21:12], 2'b00};
      n = 2;
      e = rd(a1);
      if (!e[0]) f = 2'd1;
      else if ((w && !e[1]) || (u && !e[2])) f = 2'd2;
      else begin f = 2'd0; pa = {e[31:12], va[11:0]}; end
    end
  endtask

  task automatic walk(input string tag, input logic [31:0] va, input bit w, input bit u,
                      input logic [31:0] base, input int lat);
    logic [31:0] a0, a1, pa, pend_addr;
    logic [1:0]  f;
    int n, reads = 0, gap = lat, dly = 0, cyc = 0;
    bit pend = 0, got = 0;
    model(va, w, u, base, a0, a1, n, f, pa);
    @(negedge clk);
    check({tag, " R10 ready when idle"}, {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u; root_base = base;
    @(negedge clk);
    req_valid = 1'b0; root_base = 32'hFFFF_F000;
    while (cyc < 300) begin
      if (done) begin got = 1; break; end
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
      if (req_ready) begin
        tests++; fails++;
        $display("FAIL %s R10 ready while busy actual=1 expected=0", tag);
      end
      if (pend) begin
        if (dly == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = rd(pend_addr); pend = 0; end
        else dly--;
      end else if (mem_req_valid) begin
        if (reads >= n) begin
          tests++; fails++;
          $display("FAIL %s R6 extra read actual=%0d expected=%0d", tag, reads + 1, n);
        end
        check({tag, reads == 0 ? " R2 dir addr" : " R3 table addr R9"}, mem_req_addr,
              reads == 0 ? a0 : a1);
        if (gap > 0) gap--;
        else begin
          mem_req_ready = 1'b1; pend_addr = mem_req_addr; pend = 1;
          dly = lat; gap = lat; reads++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    check({tag, " R10 done seen"}, {31'd0, got}, 32'd1);
    check({tag, " R5 R6 read count"}, reads, n);
    check({tag, " R6 R7 R8 fault"}, {30'd0, done_fault}, {30'd0, f});
    if (f == 2'd0) check({tag, " R4 R5 paddr"}, done_paddr, pa);
    @(negedge clk);
    check({tag, " R10 single pulse"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // directory at 0x0010_0000
    pmem[32'h0010_0004] = 32'h0020_0007;   // idx1 -> table 0x00200000
    pmem[32'h0020_000C] = 32'hABCD_E007;   // idx3
    pmem[32'h0010_0008] = 32'hC000_0087;   // idx2 large
    pmem[32'h0010_0010] = 32'h0030_0007;   // idx4 -> table 0x00300000
    pmem[32'h0030_0004] = 32'h1234_5005;   // read-only user
    pmem[32'h0030_0008] = 32'h2222_2003;   // supervisor writable
    pmem[32'h0010_0014] = 32'h0030_1001;   // idx5 -> table, dir read-only supervisor
    pmem[32'h0030_1000] = 32'h3333_3007;
    pmem[32'h0010_0018] = 32'h0000_0086;   // idx6 absent but other flags set
    pmem[32'h0050_0004] = 32'h8040_0087;   // other root, idx1 large

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset ready", {31'd0, req_ready}, 32'd1);
    check("R1 reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
    check("R1 reset done", {31'd0, done}, 32'd0);

    walk("4k",        32'h0040_35A4, 0, 0, 32'h0010_0000, 0);
    walk("4k_wait",   32'h0040_3FFF, 1, 1, 32'h0010_0000, 3);
    walk("large",     32'h0089_ABCD, 1, 1, 32'h0010_0000, 1);
    walk("dir_absent",32'h00C0_0000, 0, 0, 32'h0010_0000, 0);
    walk("tbl_absent",32'h0100_0123, 0, 0, 32'h0010_0000, 2);
    walk("R8 order",  32'h0100_0123, 1, 1, 32'h0010_0000, 0);
    walk("R7 tbl_ro", 32'h0100_1456, 1, 0, 32'h0010_0000, 0);
    walk("ro_read",   32'h0100_1456, 0, 1, 32'h0010_0000, 1);
    walk("R8 tbl_sup",32'h0100_2789, 0, 1, 32'h0010_0000, 0);
    walk("tbl_sup_ok",32'h0100_2789, 1, 0, 32'h0010_0000, 0);
    walk("R7 dir_ro", 32'h0140_0ABC, 1, 0, 32'h0010_0000, 2);
    walk("dir_ro_rd", 32'h0140_0ABC, 0, 0, 32'h0010_0000, 0);
    walk("R8 dir_sup",32'h0140_0ABC, 0, 1, 32'h0010_0000, 0);
    walk("R8 absent", 32'h0180_0000, 1, 1, 32'h0010_0000, 0);
    walk("root2",     32'h007F_FFFF, 0, 1, 32'h0050_0000, 4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule